// File: doc/BRIEF.md
# I2C Controller Status Flag Register

This block holds the 16-bit status word of an I2C controller that can work as bus master or as slave. The bit-level bus engine reports what happens on the bus as single-cycle event pulses: start, repeated start, stop, end of an acknowledge phase (with the sampled acknowledge level), start of a master transmission, address match, general-call match, second-byte match of a 10-bit address, master bus collision, a write into the transmit buffer, and a move of a received byte from the shift register into the receive buffer. The block turns these pulses into flags. Some flags follow the bus state and clear on their own. Others are sticky error flags that only software can clear.

Software reads the word on `status`. Software writes go through `sw_wr_en` and `sw_wr_data`. Writing 0 to a clearable error bit clears it. Every other written bit is ignored. The fill levels of the receive and transmit buffers come from outside as plain levels, and the block mirrors them into the word without a register stage. The event flags are all registered, so each one changes on the clock edge that samples its event.

Top module: `i2c_status_flags`

## Requirements
- R1: Reset (synchronous, active high) clears every flag, so `status` reads 0x0000 apart from the two mirror bits. Bits 15:12 always read 0.
- R2: Bit 2 (stop seen) sets on a stop event and clears on a start or repeated-start event. Bit 3 (start seen) does the opposite. If a start and a stop arrive together, the start wins (bit 3 = 1, bit 2 = 0).
- R3: On each end-of-acknowledge event, bit 11 takes the value of `ack_nack` (1 = NACK, 0 = ACK). Between such events it holds.
- R4: Bit 10 (master transmit busy) sets on a master-transmit-start event and clears on an end-of-acknowledge event. If both arrive together, it is set.
- R5: Bit 8 (general call) sets on a general-call match. Bit 9 (10-bit address) sets on a 10-bit second-byte match. A stop event clears both. A match arriving with a stop leaves its bit set.
- R6: Bit 7 (bus collision) sets on a collision event. It stays set until software writes 0 to bit 7.
- R7: Bit 6 (write collision) sets when the transmit buffer is written while `mod_busy` is high. Only a software write of 0 to bit 6 clears it.
- R8: Bit 5 (receive overflow) sets when a receive transfer happens while `rxbuf_full` is high. Only a software write of 0 to bit 5 clears it.
- R9: Bit 4 (data/address) clears on an address match. It sets on a transmit-buffer write or a receive transfer. An address match in the same cycle wins.
- R10: When a hardware set and a software clear of bits 7, 6 or 5 land on the same edge, the bit ends up set.
- R11: Bit 0 mirrors `rxbuf_full` and bit 1 mirrors `txbuf_full` in the same cycle. Software writes to bits 15:8, 4:0 have no effect, and writing 1 to bits 7:5 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_start | input | 1 | Start condition detected (pulse) |
| ev_rstart | input | 1 | Repeated start detected (pulse) |
| ev_stop | input | 1 | Stop condition detected (pulse) |
| ev_ack_done | input | 1 | End of an acknowledge phase (pulse) |
| ack_nack | input | 1 | Acknowledge level sampled with `ev_ack_done`, 1 = NACK |
| ev_mtx_begin | input | 1 | Master transmission begins (pulse) |
| ev_addr_match | input | 1 | Device address matched (pulse) |
| ev_gcall_match | input | 1 | General-call address matched (pulse) |
| ev_addr10_match | input | 1 | Second byte of a 10-bit address matched (pulse) |
| ev_collision | input | 1 | Bus collision during a master operation (pulse) |
| ev_txbuf_wr | input | 1 | Transmit buffer written (pulse) |
| ev_rx_xfer | input | 1 | Received byte moved into the receive buffer (pulse) |
| mod_busy | input | 1 | Controller busy level |
| rxbuf_full | input | 1 | Receive buffer holds an unread byte |
| txbuf_full | input | 1 | Transmit buffer holds an unsent byte |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_data | input | 16 | Software write data |
| status | output | 16 | Status word |

## Verification
Every registered flag answers on the rising edge that samples its event pulse or software write. The bench drives each stimulus on the falling edge, waits for one rising edge, and checks the word 1 ns later, while the inputs still hold that stimulus. That moment is also when the mirror bits reflect the levels it drove. The mirror bits have no latency at all, so a separate check changes the buffer levels between edges and reads them back before any edge. Same-edge contention cases (set against software clear, start against stop, match against stop, busy-start against acknowledge end) are each placed in one vector, so the winner is visible in the single following sample.

// File: rtl/i2c_sf_pkg.sv
package i2c_sf_pkg;

    localparam int STAT_W   = 16;
    localparam int RSVD_LO  = 12;
    localparam int N_ERR    = 3;

    // bit positions of the status word
    localparam int B_RXF    = 0;
    localparam int B_TXF    = 1;
    localparam int B_STOP   = 2;
    localparam int B_START  = 3;
    localparam int B_DATA   = 4;
    localparam int B_OVF    = 5;
    localparam int B_WCOL   = 6;
    localparam int B_BCOL   = 7;
    localparam int B_GCALL  = 8;
    localparam int B_A10    = 9;
    localparam int B_TXBSY  = 10;
    localparam int B_NACK   = 11;

    // index inside the sticky error vector
    localparam int E_OVF    = 0;
    localparam int E_WCOL   = 1;
    localparam int E_BCOL   = 2;

    typedef struct packed {
        logic start;
        logic rstart;
        logic stop;
        logic ack_done;
        logic ack_nack;
        logic mtx_begin;
        logic addr_match;
        logic gcall_match;
        logic addr10_match;
        logic collision;
        logic txbuf_wr;
        logic rx_xfer;
    } bus_ev_t;

    typedef struct packed {
        logic stop_seen;
        logic start_seen;
        logic gcall;
        logic addr10;
    } link_flags_t;

    typedef struct packed {
        logic nack;
        logic tx_busy;
        logic data_flag;
    } xfer_flags_t;

    function automatic logic [STAT_W-1:0] pack_status(
        input link_flags_t      lf,
        input xfer_flags_t      xf,
        input logic [N_ERR-1:0] ef,
        input logic             rxf,
        input logic             txf
    );
        logic [STAT_W-1:0] w;
        w          = '0;
        w[B_RXF]   = rxf;
        w[B_TXF]   = txf;
        w[B_STOP]  = lf.stop_seen;
        w[B_START] = lf.start_seen;
        w[B_DATA]  = xf.data_flag;
        w[B_OVF]   = ef[E_OVF];
        w[B_WCOL]  = ef[E_WCOL];
        w[B_BCOL]  = ef[E_BCOL];
        w[B_GCALL] = lf.gcall;
        w[B_A10]   = lf.addr10;
        w[B_TXBSY] = xf.tx_busy;
        w[B_NACK]  = xf.nack;
        return w;
    endfunction

endpackage

// File: rtl/i2c_sf_link.sv
module i2c_sf_link
    import i2c_sf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bus_ev_t     ev,
    output link_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (ev.start || ev.rstart) begin
                flags.start_seen <= 1'b1;
                flags.stop_seen  <= 1'b0;
            end else if (ev.stop) begin
                flags.stop_seen  <= 1'b1;
                flags.start_seen <= 1'b0;
            end

            if (ev.gcall_match)
                flags.gcall <= 1'b1;
            else if (ev.stop)
                flags.gcall <= 1'b0;

            if (ev.addr10_match)
                flags.addr10 <= 1'b1;
            else if (ev.stop)
                flags.addr10 <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_sf_xfer.sv
module i2c_sf_xfer
    import i2c_sf_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  bus_ev_t     ev,
    output xfer_flags_t flags
);
    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            if (ev.ack_done)
                flags.nack <= ev.ack_nack;

            if (ev.mtx_begin)
                flags.tx_busy <= 1'b1;
            else if (ev.ack_done)
                flags.tx_busy <= 1'b0;

            if (ev.addr_match)
                flags.data_flag <= 1'b0;
            else if (ev.txbuf_wr || ev.rx_xfer)
                flags.data_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/i2c_sf_sticky.sv
module i2c_sf_sticky #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] sw_clr,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (hw_set[i])
                flags[i] <= 1'b1;
            else if (sw_clr[i])
                flags[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags
    import i2c_sf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_start,
    input  logic              ev_rstart,
    input  logic              ev_stop,
    input  logic              ev_ack_done,
    input  logic              ack_nack,
    input  logic              ev_mtx_begin,
    input  logic              ev_addr_match,
    input  logic              ev_gcall_match,
    input  logic              ev_addr10_match,
    input  logic              ev_collision,
    input  logic              ev_txbuf_wr,
    input  logic              ev_rx_xfer,
    input  logic              mod_busy,
    input  logic              rxbuf_full,
    input  logic              txbuf_full,
    input  logic              sw_wr_en,
    input  logic [STAT_W-1:0] sw_wr_data,
    output logic [STAT_W-1:0] status
);
    bus_ev_t          ev;
    link_flags_t      link_q;
    xfer_flags_t      xfer_q;
    logic [N_ERR-1:0] err_set;
    logic [N_ERR-1:0] err_clr;
    logic [N_ERR-1:0] err_q;

    always_comb begin
        ev.start        = ev_start;
        ev.rstart       = ev_rstart;
        ev.stop         = ev_stop;
        ev.ack_done     = ev_ack_done;
        ev.ack_nack     = ack_nack;
        ev.mtx_begin    = ev_mtx_begin;
        ev.addr_match   = ev_addr_match;
        ev.gcall_match  = ev_gcall_match;
        ev.addr10_match = ev_addr10_match;
        ev.collision    = ev_collision;
        ev.txbuf_wr     = ev_txbuf_wr;
        ev.rx_xfer      = ev_rx_xfer;
    end

    // sticky error sources and write-zero-to-clear strobes
    always_comb begin
        err_set[E_OVF]  = ev_rx_xfer && rxbuf_full;
        err_set[E_WCOL] = ev_txbuf_wr && mod_busy;
        err_set[E_BCOL] = ev_collision;
        err_clr[E_OVF]  = sw_wr_en && !sw_wr_data[B_OVF];
        err_clr[E_WCOL] = sw_wr_en && !sw_wr_data[B_WCOL];
        err_clr[E_BCOL] = sw_wr_en && !sw_wr_data[B_BCOL];
    end

    i2c_sf_link u_link (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .flags (link_q)
    );

    i2c_sf_xfer u_xfer (
        .clk   (clk),
        .rst   (rst),
        .ev    (ev),
        .flags (xfer_q)
    );

    i2c_sf_sticky #(.N(N_ERR)) u_err (
        .clk    (clk),
        .rst    (rst),
        .hw_set (err_set),
        .sw_clr (err_clr),
        .flags  (err_q)
    );

    assign status = pack_status(link_q, xfer_q, err_q, rxbuf_full, txbuf_full);
endmodule

// File: rtl/i2c_status_flags_chk.sv
module i2c_status_flags_chk
    import i2c_sf_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ev_start,
    input logic              ev_rstart,
    input logic              ev_stop,
    input logic              ev_ack_done,
    input logic              ack_nack,
    input logic              ev_mtx_begin,
    input logic              ev_addr_match,
    input logic              ev_gcall_match,
    input logic              ev_collision,
    input logic              ev_txbuf_wr,
    input logic              ev_rx_xfer,
    input logic              mod_busy,
    input logic              rxbuf_full,
    input logic              sw_wr_en,
    input logic [STAT_W-1:0] sw_wr_data,
    input logic [STAT_W-1:0] status
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        status[STAT_W-1:RSVD_LO] == '0);                                       // R1
    AST_STOP_FLAG: assert property (@(posedge clk) disable iff (rst)
        (ev_stop && !ev_start && !ev_rstart) |=> (status[B_STOP] && !status[B_START])); // R2
    AST_NACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        ev_ack_done |=> (status[B_NACK] == $past(ack_nack)));                 // R3
    AST_TXBSY_SET: assert property (@(posedge clk) disable iff (rst)
        ev_mtx_begin |=> status[B_TXBSY]);                                    // R4
    AST_GCALL_STOP_CLR: assert property (@(posedge clk) disable iff (rst)
        (ev_stop && !ev_gcall_match) |=> !status[B_GCALL]);                   // R5
    AST_BCOL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ev_collision && !(sw_wr_en && !sw_wr_data[B_BCOL]))
        |=> (status[B_BCOL] == $past(status[B_BCOL])));                       // R6
    AST_WCOL_SET: assert property (@(posedge clk) disable iff (rst)
        (ev_txbuf_wr && mod_busy) |=> status[B_WCOL]);                        // R7
    AST_OVF_SET: assert property (@(posedge clk) disable iff (rst)
        (ev_rx_xfer && rxbuf_full) |=> status[B_OVF]);                        // R8
    AST_DATA_ADDR_CLR: assert property (@(posedge clk) disable iff (rst)
        ev_addr_match |=> !status[B_DATA]);                                   // R9
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
        ev_collision |=> status[B_BCOL]);                                     // R10
endmodule

bind i2c_status_flags i2c_status_flags_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .ev_start       (ev_start),
    .ev_rstart      (ev_rstart),
    .ev_stop        (ev_stop),
    .ev_ack_done    (ev_ack_done),
    .ack_nack       (ack_nack),
    .ev_mtx_begin   (ev_mtx_begin),
    .ev_addr_match  (ev_addr_match),
    .ev_gcall_match (ev_gcall_match),
    .ev_collision   (ev_collision),
    .ev_txbuf_wr    (ev_txbuf_wr),
    .ev_rx_xfer     (ev_rx_xfer),
    .mod_busy       (mod_busy),
    .rxbuf_full     (rxbuf_full),
    .sw_wr_en       (sw_wr_en),
    .sw_wr_data     (sw_wr_data),
    .status         (status)
);

// File: tb/tb_i2c_status_flags.sv
`timescale 1ns/1ps
module tb_i2c_status_flags;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] ev  = '0;
    logic        sw_wr_en = 1'b0;
    logic [15:0] sw_wr_data = '0;
    logic [15:0] status;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    // stimulus bit masks
    localparam logic [14:0] E_ST  = 15'h0001;
    localparam logic [14:0] E_RS  = 15'h0002;
    localparam logic [14:0] E_SP  = 15'h0004;
    localparam logic [14:0] E_AD  = 15'h0008;
    localparam logic [14:0] E_NK  = 15'h0010;
    localparam logic [14:0] E_MB  = 15'h0020;
    localparam logic [14:0] E_AM  = 15'h0040;
    localparam logic [14:0] E_GC  = 15'h0080;
    localparam logic [14:0] E_A10 = 15'h0100;
    localparam logic [14:0] E_CL  = 15'h0200;
    localparam logic [14:0] E_TW  = 15'h0400;
    localparam logic [14:0] E_RX  = 15'h0800;
    localparam logic [14:0] E_BSY = 15'h1000;
    localparam logic [14:0] E_RXF = 15'h2000;
    localparam logic [14:0] E_TXF = 15'h4000;
    localparam logic [14:0] E_0   = 15'h0000;

    localparam int NV = 17;
    // {events, write enable, write data, expected status after the edge}
    localparam logic [47:0] VEC [NV] = '{
        {E_ST,              1'b0, 16'h0000, 16'h0008},  // R2 start
        {E_MB | E_TW,       1'b0, 16'h0000, 16'h0418},  // R4 R9 tx busy, data flag
        {E_AD | E_NK,       1'b0, 16'h0000, 16'h0818},  // R3 R4 nack, busy ends
        {E_TW | E_BSY,      1'b0, 16'h0000, 16'h0858},  // R7 write while busy
        {E_RS | E_AM,       1'b0, 16'h0000, 16'h0848},  // R2 R9 address clears data
        {E_GC | E_RX | E_RXF, 1'b0, 16'h0000, 16'h0979}, // R5 R8 R9 R11
        {E_AD | E_CL,       1'b0, 16'h0000, 16'h01F8},  // R3 R6 ack, collision
        {E_0,               1'b1, 16'h0000, 16'h0118},  // R6 R7 R8 R11 sw clear
        {E_A10,             1'b0, 16'h0000, 16'h0318},  // R5 10-bit match
        {E_SP,              1'b0, 16'h0000, 16'h0014},  // R2 R5 stop clears
        {E_CL,              1'b1, 16'h0000, 16'h0094},  // R10 set beats clear
        {E_RX | E_RXF,      1'b1, 16'h0000, 16'h0035},  // R8 R10
        {E_TXF,             1'b1, 16'hFFFF, 16'h0036},  // R11 writes of 1 ignored
        {E_SP | E_GC,       1'b0, 16'h0000, 16'h0134},  // R5 match beats stop
        {E_ST | E_SP,       1'b0, 16'h0000, 16'h0038},  // R2 start beats stop
        {E_MB | E_AD | E_NK, 1'b0, 16'h0000, 16'h0C38}, // R3 R4 busy set wins
        {E_AM | E_RX,       1'b0, 16'h0000, 16'h0C28}   // R9 address wins
    };

    i2c_status_flags dut (
        .clk             (clk),
        .rst             (rst),
        .ev_start        (ev[0]),
        .ev_rstart       (ev[1]),
        .ev_stop         (ev[2]),
        .ev_ack_done     (ev[3]),
        .ack_nack        (ev[4]),
        .ev_mtx_begin    (ev[5]),
        .ev_addr_match   (ev[6]),
        .ev_gcall_match  (ev[7]),
        .ev_addr10_match (ev[8]),
        .ev_collision    (ev[9]),
        .ev_txbuf_wr     (ev[10]),
        .ev_rx_xfer      (ev[11]),
        .mod_busy        (ev[12]),
        .rxbuf_full      (ev[13]),
        .txbuf_full      (ev[14]),
        .sw_wr_en        (sw_wr_en),
        .sw_wr_data      (sw_wr_data),
        .status          (status)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: status=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run hung, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1 check("R1 reset state", status, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ev         = VEC[i][47:33];
            sw_wr_en   = VEC[i][32];
            sw_wr_data = VEC[i][31:16];
            @(posedge clk);
            #1;
            check($sformatf("vector %0d", i), status, VEC[i][15:0]);
            check("R1 reserved bits", {12'h000, status[15:12]}, 16'h0000);
        end

        // R11 mirrors change with no clock edge
        @(negedge clk);
        ev = E_RXF | E_TXF;
        sw_wr_en = 1'b0;
        #0.5 check("R11 mirror bits same cycle", {14'h0, status[1:0]}, 16'h0003);
        ev = E_0;
        #0.5 check("R11 mirror bits cleared", {14'h0, status[1:0]}, 16'h0000);

        // R1 reset in the middle of activity
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1 check("R1 reset mid-run", status, 16'h0000);
        @(negedge clk);
        rst = 1'b0;

        // R6 sticky bit held across idle cycles
        ev = E_CL;
        @(negedge clk);
        ev = E_0;
        repeat (5) @(negedge clk);
        check("R6 collision held", status, 16'h0080);

        finish_run();
    end
endmodule